// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins (28 by default) and records, per pin, that a selected signal transition has happened. Each pin has two enable bits, one in a rising-transition register and one in a falling-transition register. When a pin shows a transition whose enable bit is set, the matching bit of the edge-status register latches high. Software clears status bits by writing ones to them.

Every pin passes through a two-stage synchroniser before transition detection, so the pins may be fully asynchronous to the block clock. The status bits of the lowest eight pins drive eight dedicated interrupt lines. One summary line, meant for input position 8 of the interrupt controller, is high while any status bit is set. A simple register port writes and reads the three registers; reads are combinational from the byte address.

Top module: `gei_unit`

## Requirements
- R1: While reset is asserted and after it is released, both enable registers and the status register are zero, every dedicated interrupt line is low and the summary line is low.
- R2: Byte address 0x0 holds the rising enables, 0x4 the falling enables and 0x8 the status, bit i belonging to pin i; a read of 0x0 or 0x4 returns the last value written there, and a read of any other address returns zero.
- R3: A low-to-high change on a pin whose rising enable is set sets that pin's status bit, visible after the third rising clock edge that follows the pin change and not after the second.
- R4: A high-to-low change on a pin whose falling enable is set sets that pin's status bit.
- R5: A pin with both enables set latches status on a transition in either direction.
- R6: A transition of a type whose enable bit is clear leaves the status bit unchanged; a pin with both enables clear never latches status.
- R7: A write to 0x8 clears each status bit written with 1 and leaves each bit written with 0 unchanged; writing 0x0FFFFFFF clears every bit.
- R8: When an enabled transition is detected on the same clock edge that captures a write of 1 to that pin's status bit, the bit stays set.
- R9: Dedicated interrupt line i (i from 0 to 7) equals status bit i; status bits of higher pins do not drive any dedicated line.
- R10: The summary line is high exactly while at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 28 | Asynchronous general-purpose input pins |
| reg_wr_i | input | 1 | Register write strobe, captured on the rising clock edge |
| reg_addr_i | input | 4 | Register byte address for reads and writes |
| reg_wdata_i | input | 28 | Register write data |
| reg_rdata_o | output | 28 | Register read data for reg_addr_i |
| irq_pin_o | output | 8 | Dedicated interrupt lines for pins 0 to 7 |
| irq_sum_o | output | 1 | Summary interrupt line, high while any status bit is set |

## Verification
A pin change driven just after a clock edge reaches the status register after three further rising edges: two synchroniser stages, then the edge compare feeding the status flop. A register write takes effect at the next rising edge, and reads, the dedicated lines and the summary follow the registered state with no further delay. The scoreboard entries carry the cycle number in which their value is due, and the monitor compares them on the falling edge of that cycle; the coincident clear test places the write strobe in exactly the cycle where the detected transition is present.

// File: rtl/gei_pkg.sv
package gei_pkg;

    localparam int unsigned GEI_ADDR_W = 4;

    localparam logic [GEI_ADDR_W-1:0] OFS_RISE = 4'h0;
    localparam logic [GEI_ADDR_W-1:0] OFS_FALL = 4'h4;
    localparam logic [GEI_ADDR_W-1:0] OFS_STAT = 4'h8;

    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } gei_sel_e;

    function automatic gei_sel_e gei_decode(input logic [GEI_ADDR_W-1:0] addr);
        gei_sel_e sel;
        case (addr)
            OFS_RISE: sel = SEL_RISE;
            OFS_FALL: sel = SEL_FALL;
            OFS_STAT: sel = SEL_STAT;
            default:  sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
    parameter int unsigned WIDTH  = 28,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = async_i;
            end else begin : g_next
                assign stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_d[s];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gei_edge_detect.sv
module gei_edge_detect #(
    parameter int unsigned WIDTH = 28
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    output logic [WIDTH-1:0] hit_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [WIDTH-1:0] up_w, down_w;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        up_w      = level_i & ~st_q.prev;
        down_w    = ~level_i & st_q.prev;
        hit_o     = (up_w & rise_en_i) | (down_w & fall_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gei_regfile.sv
module gei_regfile
    import gei_pkg::*;
#(
    parameter int unsigned WIDTH = 28
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [GEI_ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]      wdata_i,
    output logic [WIDTH-1:0]      rdata_o,
    input  logic [WIDTH-1:0]      hit_i,
    output logic [WIDTH-1:0]      rise_en_o,
    output logic [WIDTH-1:0]      fall_en_o,
    output logic [WIDTH-1:0]      status_o
);

    typedef struct packed {
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] fall;
        logic [WIDTH-1:0] stat;
    } reg_state_t;

    reg_state_t st_d, st_q;
    gei_sel_e   sel_w;
    logic [WIDTH-1:0] clr_w;

    always_comb begin
        st_d  = st_q;
        sel_w = gei_decode(addr_i);
        clr_w = '0;

        if (wr_i) begin
            unique case (sel_w)
                SEL_RISE: st_d.rise = wdata_i;
                SEL_FALL: st_d.fall = wdata_i;
                SEL_STAT: clr_w     = wdata_i;
                default:  ;
            endcase
        end

        // a fresh hit wins over a clear in the same cycle
        st_d.stat = (st_q.stat & ~clr_w) | hit_i;

        unique case (sel_w)
            SEL_RISE: rdata_o = st_q.rise;
            SEL_FALL: rdata_o = st_q.fall;
            SEL_STAT: rdata_o = st_q.stat;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_en_o = st_q.rise;
    assign fall_en_o = st_q.fall;
    assign status_o  = st_q.stat;

endmodule

// File: rtl/gei_unit.sv
module gei_unit
    import gei_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 28,
    parameter int unsigned NUM_DEDIC  = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  reg_wr_i,
    input  logic [GEI_ADDR_W-1:0] reg_addr_i,
    input  logic [NUM_PINS-1:0]   reg_wdata_i,
    output logic [NUM_PINS-1:0]   reg_rdata_o,
    output logic [NUM_DEDIC-1:0]  irq_pin_o,
    output logic                  irq_sum_o
);

    logic [NUM_PINS-1:0] sync_w;
    logic [NUM_PINS-1:0] hit_w;
    logic [NUM_PINS-1:0] rise_en_w;
    logic [NUM_PINS-1:0] fall_en_w;
    logic [NUM_PINS-1:0] status_w;

    gei_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pins_i),
        .sync_o  (sync_w)
    );

    gei_edge_detect #(
        .WIDTH (NUM_PINS)
    ) u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .level_i   (sync_w),
        .rise_en_i (rise_en_w),
        .fall_en_i (fall_en_w),
        .hit_o     (hit_w)
    );

    gei_regfile #(
        .WIDTH (NUM_PINS)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .rdata_o   (reg_rdata_o),
        .hit_i     (hit_w),
        .rise_en_o (rise_en_w),
        .fall_en_o (fall_en_w),
        .status_o  (status_w)
    );

    generate
        for (genvar i = 0; i < NUM_DEDIC; i++) begin : g_dedic
            assign irq_pin_o[i] = status_w[i];
        end
    endgenerate

    assign irq_sum_o = |status_w;

endmodule

// File: rtl/gei_unit_chk.sv
module gei_unit_chk
    import gei_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 28,
    parameter int unsigned NUM_DEDIC = 8
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  reg_wr_i,
    input logic [GEI_ADDR_W-1:0] reg_addr_i,
    input logic [NUM_PINS-1:0]   reg_wdata_i,
    input logic [NUM_DEDIC-1:0]  irq_pin_o,
    input logic                  irq_sum_o,
    input logic [NUM_PINS-1:0]   hit_w,
    input logic [NUM_PINS-1:0]   rise_en_w,
    input logic [NUM_PINS-1:0]   fall_en_w,
    input logic [NUM_PINS-1:0]   status_w
);

    logic [NUM_PINS-1:0] clr_mask;
    assign clr_mask = (reg_wr_i && reg_addr_i == OFS_STAT) ? reg_wdata_i : '0;

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        !rst_ni |=> (rise_en_w == '0 && fall_en_w == '0 && status_w == '0)); // R1

    AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_w & ~(rise_en_w | fall_en_w)) == '0); // R6

    AST_SET_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_w & ~$past(status_w) & ~$past(hit_w)) == '0)); // R3

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == OFS_STAT) |=>
            ((status_w & $past(reg_wdata_i & ~hit_w)) == '0)); // R7

    AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(status_w) & ~$past(clr_mask) & ~status_w) == '0)); // R7

    AST_HIT_SURVIVES_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(hit_w) & ~status_w) == '0)); // R8

    AST_DEDIC_IN_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pin_o != '0) |-> irq_sum_o); // R10

endmodule

bind gei_unit gei_unit_chk #(
    .NUM_PINS  (NUM_PINS),
    .NUM_DEDIC (NUM_DEDIC)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .irq_pin_o   (irq_pin_o),
    .irq_sum_o   (irq_sum_o),
    .hit_w       (hit_w),
    .rise_en_w   (rise_en_w),
    .fall_en_w   (fall_en_w),
    .status_w    (status_w)
);

// File: tb/gei_unit_tb_top.sv
module gei_unit_tb_top;

    localparam int unsigned NP = 28;
    localparam int unsigned ND = 8;
    localparam int KIND_RD  = 0;
    localparam int KIND_IRQ = 1;
    localparam int KIND_SUM = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          wr = 1'b0;
    logic [3:0]    addr = '0;
    logic [NP-1:0] wdata = '0;
    logic [NP-1:0] rdata;
    logic [ND-1:0] irq_pin;
    logic          irq_sum;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gei_unit dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pins_i      (pins),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_pin_o   (irq_pin),
        .irq_sum_o   (irq_sum)
    );

    // monitor: compares due scoreboard entries on the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                KIND_RD:  act = 32'(rdata);
                KIND_IRQ: act = 32'(irq_pin);
                default:  act = 32'(irq_sum);
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)",
                         it.tag, act, it.exp, cyc);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        repeat (3) step();
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [NP-1:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        step();
        wr    = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        addr = a;
        it = '{due: cyc, kind: KIND_RD, exp: e, tag: tag};
        sb_q.push_back(it);
        step();
    endtask

    task automatic exp_out(input int kind, input logic [31:0] e, input string tag);
        sb_item_t it;
        it = '{due: cyc, kind: kind, exp: e, tag: tag};
        sb_q.push_back(it);
        step();
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        exp_out(KIND_IRQ, 0, "R1 irq lines in reset");
        rst_n = 1'b1;
        step();

        // R1: reset state
        exp_rd(4'h0, 0, "R1 rise enables");
        exp_rd(4'h4, 0, "R1 fall enables");
        exp_rd(4'h8, 0, "R1 status");
        exp_out(KIND_IRQ, 0, "R1 irq lines");
        exp_out(KIND_SUM, 0, "R1 summary");

        // R2: register map and readback
        wr_reg(4'h0, 28'h0100028);       // rise: pins 3, 5, 20
        wr_reg(4'h4, 28'h0100120);       // fall: pins 5, 8, 20
        exp_rd(4'h0, 28'h0100028, "R2 rise readback");
        exp_rd(4'h4, 28'h0100120, "R2 fall readback");
        exp_rd(4'hC, 0, "R2 unmapped read");

        // R3: rising edge on pin 3 and its latency
        pins[3] = 1'b1;
        repeat (2) step();
        exp_rd(4'h8, 0, "R3 not yet after two edges");
        exp_rd(4'h8, 28'h0000008, "R3 rising latched");
        exp_out(KIND_IRQ, 8'h08, "R9 dedicated line 3");
        exp_out(KIND_SUM, 1, "R10 summary set");

        // R7 clear, R6 disabled falling edge on pin 3
        wr_reg(4'h8, 28'h0000008);
        exp_rd(4'h8, 0, "R7 w1c bit 3");
        exp_out(KIND_SUM, 0, "R10 summary clear");
        pins[3] = 1'b0;
        settle();
        exp_rd(4'h8, 0, "R6 falling not enabled on pin 3");

        // R6: pin 10 with no enables
        pins[10] = 1'b1;
        settle();
        pins[10] = 1'b0;
        settle();
        exp_rd(4'h8, 0, "R6 masked pin 10");

        // R4: falling-only pin 8
        pins[8] = 1'b1;
        settle();
        exp_rd(4'h8, 0, "R6 rising ignored on pin 8");
        pins[8] = 1'b0;
        settle();
        exp_rd(4'h8, 28'h0000100, "R4 falling latched pin 8");
        exp_out(KIND_IRQ, 0, "R9 pin 8 has no dedicated line");
        exp_out(KIND_SUM, 1, "R10 summary from pin 8");

        // R7: writing zero leaves status
        wr_reg(4'h8, 28'h0000000);
        exp_rd(4'h8, 28'h0000100, "R7 write zero keeps status");

        // R5: both edges on pin 20
        pins[20] = 1'b1;
        settle();
        exp_rd(4'h8, 28'h0100100, "R5 rising on pin 20");
        wr_reg(4'h8, 28'h0100000);
        exp_rd(4'h8, 28'h0000100, "R7 selective clear");
        pins[20] = 1'b0;
        settle();
        exp_rd(4'h8, 28'h0100100, "R5 falling on pin 20");

        // R7: clear everything
        wr_reg(4'h8, 28'h0FFFFFF);
        wr_reg(4'h8, 28'hFFFFFFF);
        exp_rd(4'h8, 0, "R7 clear all");
        exp_out(KIND_SUM, 0, "R10 summary after clear all");

        // R8: edge coincident with clear on pin 5
        pins[5] = 1'b1;
        settle();
        exp_rd(4'h8, 28'h0000020, "R5 rising on pin 5");
        exp_out(KIND_IRQ, 8'h20, "R9 dedicated line 5");
        pins[5] = 1'b0;
        step();
        step();
        wr_reg(4'h8, 28'h0000020);
        exp_rd(4'h8, 28'h0000020, "R8 edge beats clear");
        exp_out(KIND_IRQ, 8'h20, "R8 dedicated line stays");
        wr_reg(4'h8, 28'h0000020);
        exp_rd(4'h8, 0, "R7 later clear works");

        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule